// File: doc/BRIEF.md
# Directional Binary Contour Growth Engine

This block advances a pixel-level active contour by one directional pass. The contour is a binary bitmap of a small image: a set bit marks a pixel that belongs to the contour. Each pixel also carries three signed potential values. The block adds the three potentials at every pixel. For the chosen direction it compares each pixel's total against the total at its upstream neighbour, which is the neighbour on the side opposite to the direction of travel. Where the difference is positive, and the upstream neighbour is already on the contour, the pixel joins the contour.

A collision mask stops two separate contours from merging. When topology changes are enabled, this mask is switched off.

The block computes the whole image in parallel. On a start strobe it registers the grown bitmap, and it pulses done in the following cycle. A complete evolution step is four passes, one for each direction. The caller sequences these passes and feeds the output bitmap back in as the next input bitmap. The potentials arrive precomputed. Diffusion, hole filling and edge extraction happen outside this block.

Top module: `contour_evolve`

## Requirements
- R1: While rstN is low, contourOut is all zeros and done is low.
- R2: On a rising clock edge with start high, contourOut loads the grown bitmap computed from the inputs present at that edge, and done is high for the cycle after that edge only. Without start, contourOut holds its value whatever the other inputs do.
- R3: Each potential is an 8-bit two's complement value. The pixel total is the sum of the external, internal and inflating potentials, formed without overflow, so totals from -384 to +381 compare correctly.
- R4: Pixel p receives a guiding force when total(p) minus total(upstream(p)) is strictly greater than zero. The upstream pixel is the neighbour on the side opposite the pass direction. A pixel or potential outside the image reads as zero.
- R5: New pixel p = old p OR (old upstream(p) AND force(p) AND NOT mask(p)).
- R6: For north and south passes, seed(p) = contour at the neighbour of p lying in the pass direction AND NOT contour(p). mask(p) = seed at p, at p's west neighbour or at p's east neighbour.
- R7: For east and west passes, the seed is formed the same way, but mask(p) = seed at p, at p's north neighbour or at p's south neighbour.
- R8: When topoEn is high, the mask is all zeros, so adjacent contours may join.
- R9: A pass never clears a pixel: every bit set in contourIn is set in the loaded contourOut.
- R10: Encoding. Pixel (row r, column c) is bit r*IMG_W+c of the bitmaps. Its potential is bits [(r*IMG_W+c)*8 +: 8]. Row 0 is the north edge and column 0 is the west edge. dirSel 0 = north (toward row 0), 1 = east (toward higher columns), 2 = west, 3 = south.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run one directional pass at this edge |
| dirSel | input | 2 | Pass direction code |
| topoEn | input | 1 | Allow topology changes (disables collision mask) |
| contourIn | input | IMG_W*IMG_H | Current contour bitmap |
| extPot | input | IMG_W*IMG_H*POT_W | External potential map |
| intPot | input | IMG_W*IMG_H*POT_W | Internal potential map |
| infPot | input | IMG_W*IMG_H*POT_W | Inflating potential map |
| contourOut | output | IMG_W*IMG_H | Registered grown contour |
| done | output | 1 | One-cycle pulse after a pass |

## Verification
A fault in the upstream-neighbour selection or in the border handling shows up as a pixel that appears on the wrong side of the contour, or as a growth that wraps across a row edge. Either appears in contourOut in the very cycle that done is high. A fault in the collision logic shows up as two contours that join when they should stay apart, or as growth that is blocked with no neighbour nearby. Narrow hand-built images isolate each such case. An error in the sign or width of the potential sum changes only pixels whose differences lie near zero or at the extremes. Saturated and equal-potential cases target these, and randomized images checked against an independent model cover all four directions.

// File: rtl/contour_evolve_pkg.sv
package contour_evolve_pkg;
  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_W = 2'd2,
    DIR_S = 2'd3
  } dir_e;

  typedef struct packed {
    logic capture;
  } ctrl_t;
endpackage

// File: rtl/contour_evolve_ctrl.sv
module contour_evolve_ctrl
  import contour_evolve_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output ctrl_t ctrl,
  output logic  done
);
  logic doneQ;

  assign ctrl.capture = start;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end

  assign done = doneQ;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  // R2
  done_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
endmodule

// File: rtl/contour_evolve_dp.sv
module contour_evolve_dp
  import contour_evolve_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 16,
  parameter int POT_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_t                          ctrl,
  input  logic [1:0]                     dirSel,
  input  logic                           topoEn,
  input  logic [IMG_W*IMG_H-1:0]         contourIn,
  input  logic [IMG_W*IMG_H*POT_W-1:0]   extPot,
  input  logic [IMG_W*IMG_H*POT_W-1:0]   intPot,
  input  logic [IMG_W*IMG_H*POT_W-1:0]   infPot,
  output logic [IMG_W*IMG_H-1:0]         contourQ
);
  localparam int NPIX = IMG_W * IMG_H;
  localparam int SUMW = POT_W + 2;
  localparam int DIFW = SUMW + 1;

  dir_e dir;
  logic horiz;
  assign dir   = dir_e'(dirSel);
  assign horiz = (dir == DIR_N) || (dir == DIR_S);

  logic signed [SUMW-1:0] potSum [NPIX];
  logic                   seed   [NPIX];
  logic [NPIX-1:0]        nextC;

  // Per-pixel potential sum, sign extended so three addends never overflow.
  for (genvar r = 0; r < IMG_H; r++) begin : g_sumRow
    for (genvar c = 0; c < IMG_W; c++) begin : g_sumCol
      localparam int P = r * IMG_W + c;
      logic [POT_W-1:0] e, i, f;
      assign e = extPot[P*POT_W +: POT_W];
      assign i = intPot[P*POT_W +: POT_W];
      assign f = infPot[P*POT_W +: POT_W];
      assign potSum[P] = $signed({{2{e[POT_W-1]}}, e})
                       + $signed({{2{i[POT_W-1]}}, i})
                       + $signed({{2{f[POT_W-1]}}, f});
    end
  end

  // Neighbour fetch, collision seed, mask and growth per pixel.
  for (genvar r = 0; r < IMG_H; r++) begin : g_row
    for (genvar c = 0; c < IMG_W; c++) begin : g_col
      localparam int  P  = r * IMG_W + c;
      localparam bit  HN = (r > 0);
      localparam bit  HS = (r < IMG_H - 1);
      localparam bit  HW = (c > 0);
      localparam bit  HE = (c < IMG_W - 1);
      localparam int  IN = HN ? P - IMG_W : P;
      localparam int  IS = HS ? P + IMG_W : P;
      localparam int  IW = HW ? P - 1 : P;
      localparam int  IE = HE ? P + 1 : P;

      logic cN, cS, cE, cW;
      logic sN, sS, sE, sW;
      logic signed [SUMW-1:0] pN, pS, pE, pW, srcP;
      logic signed [DIFW-1:0] diff;
      logic srcC, force_, maskBit;

      assign cN = HN ? contourIn[IN] : 1'b0;
      assign cS = HS ? contourIn[IS] : 1'b0;
      assign cW = HW ? contourIn[IW] : 1'b0;
      assign cE = HE ? contourIn[IE] : 1'b0;

      assign pN = HN ? potSum[IN] : '0;
      assign pS = HS ? potSum[IS] : '0;
      assign pW = HW ? potSum[IW] : '0;
      assign pE = HE ? potSum[IE] : '0;

      // seed: contour ahead of the pixel in the pass direction, pixel itself empty
      assign seed[P] = ((dir == DIR_N) ? cN :
                        (dir == DIR_S) ? cS :
                        (dir == DIR_E) ? cE : cW) & ~contourIn[P];

      assign sN = HN ? seed[IN] : 1'b0;
      assign sS = HS ? seed[IS] : 1'b0;
      assign sW = HW ? seed[IW] : 1'b0;
      assign sE = HE ? seed[IE] : 1'b0;

      assign maskBit = ~topoEn & (seed[P] | (horiz ? (sW | sE) : (sN | sS)));

      // upstream neighbour: opposite side of travel
      assign srcC = (dir == DIR_N) ? cS :
                    (dir == DIR_S) ? cN :
                    (dir == DIR_E) ? cW : cE;
      assign srcP = (dir == DIR_N) ? pS :
                    (dir == DIR_S) ? pN :
                    (dir == DIR_E) ? pW : pE;

      assign diff   = $signed({potSum[P][SUMW-1], potSum[P]}) - $signed({srcP[SUMW-1], srcP});
      assign force_ = ~diff[DIFW-1] & (diff != '0);

      assign nextC[P] = contourIn[P] | (srcC & force_ & ~maskBit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             contourQ <= '0;
    else if (ctrl.capture) contourQ <= nextC;
  end

  // R9
  grow_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> ((contourQ & $past(contourIn)) == $past(contourIn)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(contourQ));
endmodule

// File: rtl/contour_evolve.sv
module contour_evolve
  import contour_evolve_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 16,
  parameter int POT_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [1:0]                   dirSel,
  input  logic                         topoEn,
  input  logic [IMG_W*IMG_H-1:0]       contourIn,
  input  logic [IMG_W*IMG_H*POT_W-1:0] extPot,
  input  logic [IMG_W*IMG_H*POT_W-1:0] intPot,
  input  logic [IMG_W*IMG_H*POT_W-1:0] infPot,
  output logic [IMG_W*IMG_H-1:0]       contourOut,
  output logic                         done
);
  ctrl_t ctrl;

  contour_evolve_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .done  (done)
  );

  contour_evolve_dp #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .POT_W (POT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .dirSel    (dirSel),
    .topoEn    (topoEn),
    .contourIn (contourIn),
    .extPot    (extPot),
    .intPot    (intPot),
    .infPot    (infPot),
    .contourQ  (contourOut)
  );
endmodule

// File: tb/contour_evolve_tb_top.sv
`timescale 1ns/100ps
module contour_evolve_tb_top;
  localparam int W    = 16;
  localparam int H    = 16;
  localparam int PW   = 8;
  localparam int NPIX = W * H;

  typedef struct packed {
    logic [31:0] seed;
    logic [1:0]  dir;
    logic        topo;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h1234_5678, 2'd0, 1'b0},
    '{32'h0BAD_F00D, 2'd1, 1'b0},
    '{32'h7777_1111, 2'd2, 1'b0},
    '{32'h5A5A_A5A5, 2'd3, 1'b0},
    '{32'h0000_BEEF, 2'd0, 1'b1},
    '{32'h3141_5926, 2'd1, 1'b1},
    '{32'h2718_2818, 2'd2, 1'b1},
    '{32'h6666_9999, 2'd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN, start, topoEn;
  logic [1:0] dirSel;
  logic [NPIX-1:0] cIn, cOut;
  logic [NPIX*PW-1:0] eP, iP, fP;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [31:0] lcg;

  always #2.5 clk = ~clk;

  contour_evolve #(.IMG_W(W), .IMG_H(H), .POT_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dirSel(dirSel), .topoEn(topoEn),
    .contourIn(cIn), .extPot(eP), .intPot(iP), .infPot(fP),
    .contourOut(cOut), .done(done)
  );

  // ---------------- independent model ----------------
  function automatic bit cAt(input logic [NPIX-1:0] img, input int r, input int c);
    if (r < 0 || r >= H || c < 0 || c >= W) return 1'b0;
    return img[r*W+c];
  endfunction

  function automatic int pAt(input logic [NPIX*PW-1:0] a, input logic [NPIX*PW-1:0] b,
                             input logic [NPIX*PW-1:0] d, input int r, input int c);
    int idx;
    if (r < 0 || r >= H || c < 0 || c >= W) return 0;
    idx = r*W + c;
    return int'($signed(a[idx*PW +: PW])) + int'($signed(b[idx*PW +: PW]))
         + int'($signed(d[idx*PW +: PW]));
  endfunction

  function automatic bit seedAt(input logic [NPIX-1:0] img, input int r, input int c,
                                input int dr, input int dc);
    if (r < 0 || r >= H || c < 0 || c >= W) return 1'b0;
    return cAt(img, r+dr, c+dc) & ~cAt(img, r, c);
  endfunction

  function automatic logic [NPIX-1:0] model(input logic [NPIX-1:0] img,
      input logic [NPIX*PW-1:0] a, input logic [NPIX*PW-1:0] b,
      input logic [NPIX*PW-1:0] d, input logic [1:0] dir, input bit topo);
    logic [NPIX-1:0] res;
    int dr, dc;
    bit m, g;
    dr = (dir == 2'd0) ? -1 : (dir == 2'd3) ? 1 : 0;
    dc = (dir == 2'd1) ? 1 : (dir == 2'd2) ? -1 : 0;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        if (topo) m = 1'b0;
        else if (dr != 0)
          m = seedAt(img, r, c, dr, dc) | seedAt(img, r, c-1, dr, dc) | seedAt(img, r, c+1, dr, dc);
        else
          m = seedAt(img, r, c, dr, dc) | seedAt(img, r-1, c, dr, dc) | seedAt(img, r+1, c, dr, dc);
        g = (pAt(a, b, d, r, c) - pAt(a, b, d, r-dr, c-dc)) > 0;
        res[r*W+c] = cAt(img, r, c) | (cAt(img, r-dr, c-dc) & g & ~m);
      end
    end
    return res;
  endfunction

  // ---------------- helpers ----------------
  function automatic logic [31:0] nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic randomImage(input logic [31:0] s);
    lcg = s;
    for (int k = 0; k < NPIX; k++) begin
      logic [31:0] v;
      v = nextRand();
      cIn[k] = (v[31:29] == 3'd0);
      eP[k*PW +: PW] = v[23:16];
      iP[k*PW +: PW] = v[15:8];
      fP[k*PW +: PW] = v[7:0];
    end
  endtask

  task automatic clearAll();
    cIn = '0; eP = '0; iP = '0; fP = '0;
  endtask

  task automatic setPix(input int r, input int c);
    cIn[r*W+c] = 1'b1;
  endtask

  function automatic logic [NPIX-1:0] bitAt(input int r, input int c);
    logic [NPIX-1:0] v;
    v = '0;
    v[r*W+c] = 1'b1;
    return v;
  endfunction

  task automatic checkImg(input string req, input logic [NPIX-1:0] act, input logic [NPIX-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one pass: inputs driven away from edge, result sampled at next negedge
  task automatic runPass(input logic [1:0] d, input bit topo);
    @(negedge clk);
    dirSel = d; topoEn = topo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [NPIX-1:0] exp, held;
    rstN = 1'b0; start = 1'b0; topoEn = 1'b0; dirSel = 2'd0;
    clearAll();
    repeat (3) @(negedge clk);
    // R1 reset state
    checkImg("R1 contourOut in reset", cOut, '0);
    checkBit("R1 done in reset", done, 1'b0);
    rstN = 1'b1;

    // vector table walk (R4 R5 R6 R7 R8 R10)
    foreach (VECS[k]) begin
      randomImage(VECS[k].seed);
      exp = model(cIn, eP, iP, fP, VECS[k].dir, VECS[k].topo);
      runPass(VECS[k].dir, VECS[k].topo);
      checkImg("R5 table vector", cOut, exp);
      checkBit("R2 done after table pass", done, 1'b1);
    end

    // randomized sweep over all directions with feedback (R9)
    for (int t = 0; t < 12; t++) begin
      randomImage(32'hC0DE_0000 + t);
      for (int d = 0; d < 4; d++) begin
        exp = model(cIn, eP, iP, fP, d[1:0], t[0]);
        runPass(d[1:0], t[0]);
        checkImg("R9 random sweep", cOut, exp);
        cIn = cOut;
      end
    end

    // R2 done lasts a single cycle, contour holds without start
    held = cOut;
    @(negedge clk);
    checkBit("R2 done single cycle", done, 1'b0);
    randomImage(32'h0F0F_0F0F);
    dirSel = 2'd3;
    repeat (3) @(negedge clk);
    checkImg("R2 hold without start", cOut, held);

    // R4 R5: single pixel grows north into positive potential
    clearAll(); setPix(5, 5);
    eP[(4*W+5)*PW +: PW] = 8'd10;
    runPass(2'd0, 1'b1);
    checkImg("R4 north growth", cOut, bitAt(5,5) | bitAt(4,5));

    // R4 equal potential gives no force
    clearAll(); setPix(5, 5);
    runPass(2'd0, 1'b1);
    checkImg("R4 zero difference", cOut, bitAt(5,5));

    // R3 negative total does not grow
    clearAll(); setPix(5, 5);
    eP[(4*W+5)*PW +: PW] = 8'hFF;
    runPass(2'd0, 1'b1);
    checkImg("R3 negative total", cOut, bitAt(5,5));

    // R3 extremes: +381 against -384, no overflow
    clearAll(); setPix(5, 5);
    eP[(4*W+5)*PW +: PW] = 8'd127; iP[(4*W+5)*PW +: PW] = 8'd127; fP[(4*W+5)*PW +: PW] = 8'd127;
    eP[(5*W+5)*PW +: PW] = 8'h80;  iP[(5*W+5)*PW +: PW] = 8'h80;  fP[(5*W+5)*PW +: PW] = 8'h80;
    runPass(2'd0, 1'b1);
    checkImg("R3 saturated sum", cOut, bitAt(5,5) | bitAt(4,5));

    // R6 collision blocks north growth between two contours
    clearAll(); setPix(5, 5); setPix(3, 5);
    eP[(4*W+5)*PW +: PW] = 8'd10;
    runPass(2'd0, 1'b0);
    checkImg("R6 north collision", cOut, bitAt(5,5) | bitAt(3,5));

    // R6 horizontal spread: seed at (3,6) masks (3,5)
    clearAll(); setPix(4, 5); setPix(2, 6);
    eP[(3*W+5)*PW +: PW] = 8'd10;
    runPass(2'd0, 1'b0);
    checkImg("R6 horizontal spread", cOut, bitAt(4,5) | bitAt(2,6));

    // R8 topology enabled lets the same case join
    clearAll(); setPix(5, 5); setPix(3, 5);
    eP[(4*W+5)*PW +: PW] = 8'd10;
    runPass(2'd0, 1'b1);
    checkImg("R8 topology enabled", cOut, bitAt(5,5) | bitAt(3,5) | bitAt(4,5));

    // R7 east pass: vertical spread masks (5,6) from seed at (4,6)
    clearAll(); setPix(5, 5); setPix(4, 7);
    eP[(5*W+6)*PW +: PW] = 8'd10;
    runPass(2'd1, 1'b0);
    checkImg("R7 vertical spread", cOut, bitAt(5,5) | bitAt(4,7));

    // R7 seed two rows away does not mask
    clearAll(); setPix(5, 5); setPix(3, 7);
    eP[(5*W+6)*PW +: PW] = 8'd10;
    runPass(2'd1, 1'b0);
    checkImg("R7 distant seed", cOut, bitAt(5,5) | bitAt(3,7) | bitAt(5,6));

    // R10 west and south directions
    clearAll(); setPix(8, 8);
    eP[(8*W+7)*PW +: PW] = 8'd5;
    eP[(9*W+8)*PW +: PW] = 8'd5;
    runPass(2'd2, 1'b1);
    checkImg("R10 west code", cOut, bitAt(8,8) | bitAt(8,7));
    runPass(2'd3, 1'b1);
    checkImg("R10 south code", cOut, bitAt(8,8) | bitAt(9,8));

    // R4 border: east pass never wraps from column 15 into next row
    clearAll(); setPix(0, 15);
    eP[(1*W+0)*PW +: PW] = 8'd10;
    runPass(2'd1, 1'b1);
    checkImg("R4 border no wrap", cOut, bitAt(0,15));

    // R1 reset mid-run clears the output
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkImg("R1 reset clears", cOut, '0);
    rstN = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule